// File: doc/BRIEF.md
# Single-Bus Register ADD Sequencer

This block carries out a register-to-register addition on a small datapath. It has four general registers, two temporaries (Y and Z), one shared bus and an adder. A start pulse latches a 2-bit source field and a 2-bit destination field, and the result is written as `dst <= dst + src`.

The control side does not know in advance which registers will be used. It steps through a fixed three-step sequence that raises abstract strobes: source-out, destination-out and destination-in. Two small decoders turn the latched fields into one-hot register selects. Each register's bus-drive enable and load enable is then formed by gating a generic strobe with the matching select line. The same three steps therefore serve every register pair.

The per-register enables, the temporary-register strobes, the add select, the end flag and the bus value are all brought out, so the sequence can be observed from outside. A parameter gives the register contents after reset. Its default value is zero.

Top module: `xfer_add_unit`

## Requirements
- R1: While reset is high, and in the cycle after it, the step counter is idle and every enable and strobe output is low. The bus reads zero. Register i holds slice i of `RESET_IMAGE` (bits i*REG_W upward), and Y and Z hold zero.
- R2: A start pulse seen in the idle state latches `srcField` and `dstField`. The three cycles that follow are steps one, two and three, in that order.
- R3: In step one, `regOutEn` is the one-hot code of the latched source (bit i selects register i). `yIn` is high, and the bus carries that register's value.
- R4: In step two, `regOutEn` is the one-hot code of the latched destination. `aluAdd` and `zIn` are high, and the bus carries the destination's value.
- R5: In step three, `zOut` and `done` are high and `regOutEn` is zero. `regInEn` is the one-hot code of the destination. The bus carries the sum, and the destination holds that sum from the next cycle on.
- R6: In any cycle at most one of the four register out enables and `zOut` is high. When none is high, the bus reads zero.
- R7: The sum wraps modulo 2^REG_W.
- R8: When source and destination name the same register, that register ends up doubled (mod 2^REG_W).
- R9: A start pulse during steps one to three is ignored. Changes on the field inputs during those steps have no effect on the operation in flight.
- R10: `done` is high for exactly one cycle, after which the block is idle. A start in that idle cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an ADD when idle |
| srcField | input | 2 | Source register number |
| dstField | input | 2 | Destination register number |
| regOutEn | output | 4 | Per-register bus drive enable, bit i = register i |
| regInEn | output | 4 | Per-register load enable, bit i = register i |
| yIn | output | 1 | Y captures the bus |
| zIn | output | 1 | Z captures the adder output |
| zOut | output | 1 | Z drives the bus |
| aluAdd | output | 1 | Adder selects A+B (A from Y, B from bus) |
| done | output | 1 | Final step of the sequence |
| busValue | output | 8 | Value on the shared bus |

## Verification
The assertions rely on `start` and the field inputs being driven only while reset is low and settling well before each clock edge. They also rely on reset being held for at least one edge. The bench changes these inputs only on the falling edge of the clock. It deliberately pulses start and changes the fields while a sequence is running, so that the "ignored" properties are exercised rather than assumed. It also drops reset into the middle of a sequence to confirm that the assertions recover once reset is released.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [1:0] {
    STEP_IDLE = 2'd0,
    STEP_ONE  = 2'd1,
    STEP_TWO  = 2'd2,
    STEP_THREE = 2'd3
  } stepT;

  typedef struct packed {
    logic srcOut;
    logic dstOut;
    logic dstIn;
    logic yIn;
    logic zIn;
    logic zOut;
    logic aluAdd;
    logic endStep;
  } strobeT;

  typedef struct packed {
    logic yIn;
    logic zIn;
    logic zOut;
    logic aluAdd;
  } dpCtrlT;

endpackage

// File: rtl/xfer_decoder.sv
module xfer_decoder #(
  parameter int NUM_LINES = 4,
  localparam int CODE_W = $clog2(NUM_LINES)
) (
  input  logic [CODE_W-1:0]    code,
  output logic [NUM_LINES-1:0] oneHot
);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign oneHot[i] = (code == CODE_W'(i));
  end

endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int NUM_REGS = 4,
  localparam int SEL_W = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [SEL_W-1:0]    srcField,
  input  logic [SEL_W-1:0]    dstField,
  output dpCtrlT              dpCtrl,
  output logic                endStep,
  output logic [NUM_REGS-1:0] regOutEn,
  output logic [NUM_REGS-1:0] regInEn
);

  stepT             step;
  logic [SEL_W-1:0] srcLatch;
  logic [SEL_W-1:0] dstLatch;
  strobeT           strobes;
  logic [NUM_REGS-1:0] srcSel;
  logic [NUM_REGS-1:0] dstSel;

  always_ff @(posedge clk) begin
    if (rst) begin
      step     <= STEP_IDLE;
      srcLatch <= '0;
      dstLatch <= '0;
    end else begin
      unique case (step)
        STEP_IDLE: begin
          if (start) begin
            step     <= STEP_ONE;
            srcLatch <= srcField;
            dstLatch <= dstField;
          end
        end
        STEP_ONE:   step <= STEP_TWO;
        STEP_TWO:   step <= STEP_THREE;
        STEP_THREE: step <= STEP_IDLE;
        default:    step <= STEP_IDLE;
      endcase
    end
  end

  // Generic strobes: independent of which registers are named
  always_comb begin
    strobes = '0;
    unique case (step)
      STEP_ONE: begin
        strobes.srcOut = 1'b1;
        strobes.yIn    = 1'b1;
      end
      STEP_TWO: begin
        strobes.dstOut = 1'b1;
        strobes.aluAdd = 1'b1;
        strobes.zIn    = 1'b1;
      end
      STEP_THREE: begin
        strobes.zOut    = 1'b1;
        strobes.dstIn   = 1'b1;
        strobes.endStep = 1'b1;
      end
      default: strobes = '0;
    endcase
  end

  xfer_decoder #(.NUM_LINES(NUM_REGS)) u_srcDec (
    .code   (srcLatch),
    .oneHot (srcSel)
  );

  xfer_decoder #(.NUM_LINES(NUM_REGS)) u_dstDec (
    .code   (dstLatch),
    .oneHot (dstSel)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_gate
    assign regOutEn[i] = (strobes.srcOut & srcSel[i]) | (strobes.dstOut & dstSel[i]);
    assign regInEn[i]  = strobes.dstIn & dstSel[i];
  end

  assign dpCtrl.yIn    = strobes.yIn;
  assign dpCtrl.zIn    = strobes.zIn;
  assign dpCtrl.zOut   = strobes.zOut;
  assign dpCtrl.aluAdd = strobes.aluAdd;
  assign endStep       = strobes.endStep;

  // R6
  single_driver_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({regOutEn, dpCtrl.zOut}));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_IDLE && start) |=> (step == STEP_ONE));

  // R9
  fields_held_chk: assert property (@(posedge clk) disable iff (rst)
    (step != STEP_IDLE) |=> ($stable(srcLatch) && $stable(dstLatch)));

  // R10
  end_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    endStep |=> (step == STEP_IDLE && !endStep));

  // R5
  load_only_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    (regInEn != '0) |-> (endStep && $onehot(regInEn)));

endmodule

// File: rtl/xfer_datapath.sv
module xfer_datapath
  import xfer_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int REG_W = 8,
  parameter logic [NUM_REGS*REG_W-1:0] RESET_IMAGE = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  dpCtrlT              dpCtrl,
  input  logic [NUM_REGS-1:0] regOutEn,
  input  logic [NUM_REGS-1:0] regInEn,
  output logic [REG_W-1:0]    busValue
);

  logic [REG_W-1:0] regs [NUM_REGS];
  logic [REG_W-1:0] yReg;
  logic [REG_W-1:0] zReg;
  logic [REG_W-1:0] adderOut;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)             regs[i] <= RESET_IMAGE[i*REG_W +: REG_W];
      else if (regInEn[i]) regs[i] <= busValue;
    end

    // R5
    reg_load_chk: assert property (@(posedge clk) disable iff (rst)
      regInEn[i] |=> (regs[i] == $past(busValue)));
  end

  // AND-OR bus: zero when no source is enabled
  always_comb begin
    busValue = dpCtrl.zOut ? zReg : '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      busValue = busValue | (regOutEn[i] ? regs[i] : '0);
    end
  end

  assign adderOut = dpCtrl.aluAdd ? (yReg + busValue) : busValue;

  always_ff @(posedge clk) begin
    if (rst) begin
      yReg <= '0;
      zReg <= '0;
    end else begin
      if (dpCtrl.yIn) yReg <= busValue;
      if (dpCtrl.zIn) zReg <= adderOut;
    end
  end

  // R3
  y_capture_chk: assert property (@(posedge clk) disable iff (rst)
    dpCtrl.yIn |=> (yReg == $past(busValue)));

  // R7
  z_wrap_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (dpCtrl.zIn && dpCtrl.aluAdd) |=> (zReg == REG_W'($past(yReg) + $past(busValue))));

  // R6
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (regOutEn == '0 && !dpCtrl.zOut) |-> (busValue == '0));

endmodule

// File: rtl/xfer_add_unit.sv
module xfer_add_unit
  import xfer_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int REG_W = 8,
  parameter logic [NUM_REGS*REG_W-1:0] RESET_IMAGE = '0,
  localparam int SEL_W = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [SEL_W-1:0]    srcField,
  input  logic [SEL_W-1:0]    dstField,
  output logic [NUM_REGS-1:0] regOutEn,
  output logic [NUM_REGS-1:0] regInEn,
  output logic                yIn,
  output logic                zIn,
  output logic                zOut,
  output logic                aluAdd,
  output logic                done,
  output logic [REG_W-1:0]    busValue
);

  dpCtrlT dpCtrl;

  xfer_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .srcField (srcField),
    .dstField (dstField),
    .dpCtrl   (dpCtrl),
    .endStep  (done),
    .regOutEn (regOutEn),
    .regInEn  (regInEn)
  );

  xfer_datapath #(
    .NUM_REGS    (NUM_REGS),
    .REG_W       (REG_W),
    .RESET_IMAGE (RESET_IMAGE)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .dpCtrl   (dpCtrl),
    .regOutEn (regOutEn),
    .regInEn  (regInEn),
    .busValue (busValue)
  );

  assign yIn    = dpCtrl.yIn;
  assign zIn    = dpCtrl.zIn;
  assign zOut   = dpCtrl.zOut;
  assign aluAdd = dpCtrl.aluAdd;

endmodule

// File: tb/xfer_add_unit_tb.sv
module xfer_add_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NREG = 4;
  localparam int W = 8;
  localparam logic [NREG*W-1:0] IMAGE = 32'hF0_80_05_03;
  localparam int NVEC = 6;
  // {src, dst}
  localparam logic [3:0] VEC [NVEC] = '{
    {2'd1, 2'd0}, {2'd2, 2'd2}, {2'd3, 2'd1},
    {2'd3, 2'd3}, {2'd0, 2'd3}, {2'd1, 2'd2}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] srcField = '0;
  logic [1:0] dstField = '0;
  logic [NREG-1:0] regOutEn, regInEn;
  logic yIn, zIn, zOut, aluAdd, done;
  logic [W-1:0] busValue;

  logic [W-1:0] model [NREG];
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_add_unit #(.NUM_REGS(NREG), .REG_W(W), .RESET_IMAGE(IMAGE)) u_dut (
    .clk(clk), .rst(rst), .start(start), .srcField(srcField), .dstField(dstField),
    .regOutEn(regOutEn), .regInEn(regInEn), .yIn(yIn), .zIn(zIn), .zOut(zOut),
    .aluAdd(aluAdd), .done(done), .busValue(busValue)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic loadModel();
    for (int i = 0; i < NREG; i++) model[i] = IMAGE[i*W +: W];
  endtask

  task automatic chkIdle(input string req);
    chk(req, {regOutEn, regInEn, yIn, zIn, zOut, aluAdd, done}, '0);
    chk(req, busValue, '0);
  endtask

  // Launch at a falling edge; returns at the falling edge after step three
  task automatic runOp(input logic [1:0] s, input logic [1:0] d, input bit disturb);
    logic [W-1:0] sum;
    srcField = s; dstField = d; start = 1'b1;
    @(negedge clk);
    start = disturb;
    if (disturb) begin srcField = ~s; dstField = ~d; end
    chk("R3 step one enables", {regOutEn, regInEn, yIn, zIn, aluAdd, zOut},
        {4'(1 << s), 4'b0, 1'b1, 1'b0, 1'b0, 1'b0});
    chk("R3 source on bus", busValue, model[s]);
    @(negedge clk);
    chk("R4 step two enables", {regOutEn, regInEn, yIn, zIn, aluAdd, zOut},
        {4'(1 << d), 4'b0, 1'b0, 1'b1, 1'b1, 1'b0});
    chk("R4 destination on bus", busValue, model[d]);
    @(negedge clk);
    sum = W'(model[s] + model[d]);
    chk("R5 step three enables", {regOutEn, regInEn, zOut, done, yIn, zIn},
        {4'b0, 4'(1 << d), 1'b1, 1'b1, 1'b0, 1'b0});
    chk("R7 sum on bus", busValue, sum);
    model[d] = sum;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    loadModel();
    @(negedge clk);
    chkIdle("R1 during reset");
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chkIdle("R1 after reset");

    // Vector table: each op also reads back prior results through the bus
    for (int k = 0; k < NVEC; k++) begin
      runOp(VEC[k][3:2], VEC[k][1:0], 1'b0);
      chkIdle("R10 idle after done");
    end

    // R8: doubling with explicit expected value (R1 = 0xF5 -> 0xEA)
    chk("R8 model precondition", model[1], 8'hF5);
    runOp(2'd1, 2'd1, 1'b0);
    chk("R8 doubled", model[1], 8'hEA);

    // R9: start held and fields changed during the operation
    runOp(2'd0, 2'd1, 1'b1);
    chkIdle("R9 start during busy ignored");
    @(negedge clk);
    chkIdle("R9 still idle");

    // R10: back-to-back start in the idle cycle right after done
    runOp(2'd2, 2'd0, 1'b0);
    runOp(2'd0, 2'd0, 1'b0);
    // R6: idle bus reads zero between operations
    @(negedge clk);
    chk("R6 idle bus zero", busValue, '0);

    // R1: reset in the middle of a sequence restores the image
    srcField = 2'd3; dstField = 2'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chkIdle("R1 mid-op reset");
    rst = 1'b0;
    loadModel();
    @(negedge clk);
    chkIdle("R1 idle after mid-op reset");
    for (int r = 0; r < NREG; r++) begin
      runOp(2'(r), 2'(r), 1'b0);
    end
    // R7 wrap: R3 image 0xF0 doubled = 0xE0
    chk("R7 wrap value", model[3], 8'hE0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule